// File: doc/BRIEF.md
# Shared-Bus Request/Grant Arbiter with Atomic Lock

This block arbitrates a shared parallel bus among `N` masters (three by default). Each master has its own active-low request input. The arbiter drives one active-low grant output per master, and at most one of them is low at a time. The grant is registered and moves only on a clock edge where the bus is idle, meaning the frame and initiator-ready inputs are both high. When no master is requesting, the grant stays parked on the master that held it last.

A run-time input selects the priority scheme: fixed priority, with master 0 highest, or rotating priority that starts from the master after the one most recently granted.

The arbiter also follows an active-low atomic-lock line. Holding a grant does not make a master the lock owner. The granted master becomes owner when the lock line is seen low on an idle edge. Ownership ends when the lock line is seen high on an idle edge.

A second run-time input selects one of two lock modes:
- **Resource-lock mode:** other masters keep being granted while a lock is held.
- **System-lock mode:** only the owner may receive the grant while the lock line stays low.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After reset all grant outputs are high (no grant), and in every cycle at most one grant output is low.
- R2: The grant outputs change only after a rising edge at which `frame_n` and `irdy_n` were both high.
- R3: With `rotate_sel` = 0, on an idle edge the lowest-numbered requesting master is granted (master 0 highest).
- R4: With `rotate_sel` = 1, on an idle edge the first requesting master after the most recently granted one, in ascending order with wrap-around, is granted. After reset the search starts at master 0.
- R5: When no request input is low at an idle edge, the grant stays on the master that last held it (none after reset).
- R6: A master whose request input is high (released or left unconnected) is never newly granted.
- R7: The master holding the grant becomes lock owner at an idle edge where `lock_n` is low and no owner exists. A master that is only granted, with `lock_n` high, does not become owner.
- R8: With `sys_lock` = 0, a held lock does not stop the grant moving to other requesting masters.
- R9: With `sys_lock` = 1, while `lock_n` is low and an owner exists, the grant may only move to the owner. If the owner is not requesting, the grant stays where it is.
- R10: Lock ownership is cleared at an idle edge where `lock_n` is high, after which any requester may be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N | Per-master request, active low |
| frame_n | input | 1 | Bus frame, active low (high means no transaction framed) |
| irdy_n | input | 1 | Initiator ready, active low |
| lock_n | input | 1 | Atomic-lock line, active low |
| rotate_sel | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| sys_lock | input | 1 | 0 selects resource-lock mode, 1 selects system-lock mode |
| gnt_n | output | N | Per-master grant, active low, at most one low |

## Verification
Several properties are checked on every cycle:
- the single-grant invariant;
- grant stability on busy edges and on idle edges with no requests;
- that a newly granted master was requesting;
- that the grant cannot leave for a non-owner during a system lock;
- the take-over and release of lock ownership.

Other behaviour needs scripted sequences and can only be shown by the bench's scenarios. This covers which master wins under each priority scheme, the order of rotation across several rounds, and how ownership, once taken, steers later grants in both lock modes.

// File: rtl/arb_lock_pkg.sv
package arb_lock_pkg;
  typedef enum logic {SCH_FIXED = 1'b0, SCH_ROTATE = 1'b1} sched_e;
  typedef enum logic {LK_RESOURCE = 1'b0, LK_SYSTEM = 1'b1} lock_mode_e;
endpackage

// File: rtl/arb_lock_track.sv
// Tracks which master owns the atomic lock, separately from the grant.
module arb_lock_track #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_idle,
  input  logic          lock_n,
  input  logic          gnt_vld,
  input  logic [IW-1:0] gnt_idx,
  output logic          owner_vld,
  output logic [IW-1:0] owner_idx,
  output logic          held_vld,
  output logic [IW-1:0] held_idx
);
  // held_*: lock in force for this edge, including a take-over happening now
  always_comb begin
    held_vld = !lock_n && (owner_vld || (bus_idle && gnt_vld));
    held_idx = owner_vld ? owner_idx : gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_idx <= '0;
    end else if (bus_idle) begin
      if (lock_n) begin
        owner_vld <= 1'b0;
      end else if (!owner_vld && gnt_vld) begin
        owner_vld <= 1'b1;
        owner_idx <= gnt_idx;
      end
    end
  end
endmodule

// File: rtl/arb_pick.sv
// Chooses a winner among eligible requesters, fixed or rotating order.
module arb_pick #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  arb_lock_pkg::sched_e scheme,
  input  logic [N-1:0]         elig,
  input  logic [IW-1:0]        last_idx,
  output logic                 win_vld,
  output logic [IW-1:0]        win_idx
);
  logic [IW-1:0] fix_idx;
  logic [IW-1:0] rot_idx;

  // fixed: scan high to low so the lowest index is written last
  always_comb begin
    fix_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) fix_idx = IW'(i);
    end
  end

  // rotating: scan offsets far to near so the nearest successor wins
  always_comb begin
    rot_idx = '0;
    for (int off = N; off >= 1; off--) begin
      int cand;
      cand = (int'(last_idx) + off) % N;
      if (elig[cand]) rot_idx = IW'(cand);
    end
  end

  assign win_vld = |elig;
  assign win_idx = (scheme == arb_lock_pkg::SCH_ROTATE) ? rot_idx : fix_idx;
endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic         frame_n,
  input  logic         irdy_n,
  input  logic         lock_n,
  input  logic         rotate_sel,
  input  logic         sys_lock,
  output logic [N-1:0] gnt_n
);
  import arb_lock_pkg::*;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  sched_e        scheme;
  lock_mode_e    lk_mode;
  logic          bus_idle;
  logic [N-1:0]  req;
  logic [N-1:0]  gnt_q;
  logic [IW-1:0] last_idx;
  logic          gnt_vld;
  logic [IW-1:0] gnt_idx;
  logic          owner_vld;
  logic [IW-1:0] owner_idx;
  logic          held_vld;
  logic [IW-1:0] held_idx;
  logic [N-1:0]  elig;
  logic          win_vld;
  logic [IW-1:0] win_idx;

  assign scheme   = sched_e'(rotate_sel);
  assign lk_mode  = lock_mode_e'(sys_lock);
  assign bus_idle = frame_n & irdy_n;
  assign req      = ~req_n;
  assign gnt_vld  = |gnt_q;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_q[i]) gnt_idx = IW'(i);
    end
  end

  // in system-lock mode only the owner stays eligible while the lock holds
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (lk_mode == LK_SYSTEM && held_vld)
        elig[i] = req[i] && (held_idx == IW'(i));
      else
        elig[i] = req[i];
    end
  end

  arb_lock_track #(.N(N), .IW(IW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_idle  (bus_idle),
    .lock_n    (lock_n),
    .gnt_vld   (gnt_vld),
    .gnt_idx   (gnt_idx),
    .owner_vld (owner_vld),
    .owner_idx (owner_idx),
    .held_vld  (held_vld),
    .held_idx  (held_idx)
  );

  arb_pick #(.N(N), .IW(IW)) u_pick (
    .scheme   (scheme),
    .elig     (elig),
    .last_idx (last_idx),
    .win_vld  (win_vld),
    .win_idx  (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      last_idx <= IW'(N - 1);
    end else if (bus_idle && win_vld) begin
      for (int i = 0; i < N; i++) gnt_q[i] <= (win_idx == IW'(i));
      last_idx <= win_idx;
    end
  end

  assign gnt_n = ~gnt_q;
endmodule

// File: rtl/bus_lock_arbiter_chk.sv
module bus_lock_arbiter_chk #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_n,
  input logic          frame_n,
  input logic          irdy_n,
  input logic          lock_n,
  input logic          sys_lock,
  input logic [N-1:0]  gnt_n,
  input logic          owner_vld,
  input logic [IW-1:0] owner_idx
);
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  a_r2_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_n && irdy_n) |=> $stable(gnt_n));

  a_r5_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && irdy_n && (&req_n)) |=> $stable(gnt_n));

  a_r6_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && irdy_n) |=> ((gnt_n == $past(gnt_n)) || ((~gnt_n & ~$past(req_n)) != '0)));

  a_r7_take_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_vld && !lock_n && frame_n && irdy_n && (gnt_n != '1)) |=> owner_vld);

  a_r9_system_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_lock && owner_vld && !lock_n) |=> ((gnt_n == $past(gnt_n)) || !gnt_n[$past(owner_idx)]));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && lock_n && frame_n && irdy_n) |=> !owner_vld);
endmodule

bind bus_lock_arbiter bus_lock_arbiter_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_n     (req_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .lock_n    (lock_n),
  .sys_lock  (sys_lock),
  .gnt_n     (gnt_n),
  .owner_vld (owner_vld),
  .owner_idx (owner_idx)
);

// File: tb/test_bus_lock_arbiter.sv
module test_bus_lock_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_n = 3'b111;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic       lock_n = 1'b1;
  logic       rotate_sel = 1'b0;
  logic       sys_lock = 1'b0;
  logic [2:0] gnt_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bus_lock_arbiter #(.N(3)) i_bus_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .lock_n(lock_n), .rotate_sel(rotate_sel), .sys_lock(sys_lock), .gnt_n(gnt_n)
  );

  // {tag, rotate, sys, frame_n, irdy_n, lock_n, req_n, expected gnt_n}
  // bit k of req_n/gnt_n belongs to master k
  localparam int NV = 24;
  localparam logic [14:0] VEC [NV] = '{
    {4'd3,  1'b0,1'b0,1'b1,1'b1,1'b1, 3'b110, 3'b110}, // R3 m0 alone
    {4'd3,  1'b0,1'b0,1'b1,1'b1,1'b1, 3'b000, 3'b110}, // R3 all, m0 wins
    {4'd3,  1'b0,1'b0,1'b1,1'b1,1'b1, 3'b001, 3'b101}, // R3 m1 beats m2
    {4'd2,  1'b0,1'b0,1'b0,1'b1,1'b1, 3'b011, 3'b101}, // R2 frame busy
    {4'd2,  1'b0,1'b0,1'b1,1'b0,1'b1, 3'b011, 3'b101}, // R2 irdy busy
    {4'd3,  1'b0,1'b0,1'b1,1'b1,1'b1, 3'b011, 3'b011}, // R3 m2 alone
    {4'd5,  1'b0,1'b0,1'b1,1'b1,1'b1, 3'b111, 3'b011}, // R5 park
    {4'd4,  1'b1,1'b0,1'b1,1'b1,1'b1, 3'b000, 3'b110}, // R4 after m2 -> m0
    {4'd4,  1'b1,1'b0,1'b1,1'b1,1'b1, 3'b000, 3'b101}, // R4 -> m1
    {4'd4,  1'b1,1'b0,1'b1,1'b1,1'b1, 3'b000, 3'b011}, // R4 -> m2
    {4'd4,  1'b1,1'b0,1'b1,1'b1,1'b1, 3'b010, 3'b110}, // R4 wrap to m0
    {4'd4,  1'b1,1'b0,1'b1,1'b1,1'b1, 3'b010, 3'b011}, // R4 skip idle m1
    {4'd5,  1'b1,1'b0,1'b1,1'b1,1'b1, 3'b111, 3'b011}, // R5 park in rotate
    {4'd7,  1'b0,1'b0,1'b1,1'b1,1'b0, 3'b011, 3'b011}, // R7 m2 takes lock
    {4'd2,  1'b0,1'b0,1'b0,1'b1,1'b0, 3'b011, 3'b011}, // R2 busy locked
    {4'd8,  1'b0,1'b0,1'b1,1'b1,1'b0, 3'b110, 3'b110}, // R8 m0 granted under lock
    {4'd9,  1'b0,1'b1,1'b1,1'b1,1'b0, 3'b101, 3'b110}, // R9 m1 refused
    {4'd9,  1'b0,1'b1,1'b1,1'b1,1'b0, 3'b001, 3'b011}, // R9 owner m2 wins
    {4'd9,  1'b0,1'b1,1'b1,1'b1,1'b0, 3'b100, 3'b011}, // R9 m0,m1 refused
    {4'd2,  1'b0,1'b1,1'b0,1'b1,1'b1, 3'b100, 3'b011}, // R2 release while busy
    {4'd10, 1'b0,1'b1,1'b1,1'b1,1'b1, 3'b100, 3'b110}, // R10 released, m0 wins
    {4'd7,  1'b0,1'b1,1'b1,1'b1,1'b0, 3'b110, 3'b110}, // R7 m0 takes lock
    {4'd7,  1'b0,1'b1,1'b1,1'b1,1'b0, 3'b001, 3'b110}, // R7 owner is m0 not others
    {4'd10, 1'b0,1'b1,1'b1,1'b1,1'b1, 3'b101, 3'b101}  // R10 cleared, m1 wins
  };

  task automatic check(input int tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d gnt_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, gnt_n, 3'b111); // R1 reset state
    rst_n = 1'b1;
    step();
    check(5, gnt_n, 3'b111); // R5 no requests, nothing granted

    for (int v = 0; v < NV; v++) begin
      rotate_sel = VEC[v][10];
      sys_lock   = VEC[v][9];
      frame_n    = VEC[v][8];
      irdy_n     = VEC[v][7];
      lock_n     = VEC[v][6];
      req_n      = VEC[v][5:3];
      step();
      check(int'(VEC[v][14:11]), gnt_n, VEC[v][2:0]);
      checks++;
      if ($countones(~gnt_n) > 1) begin // R1
        errors++;
        $display("FAIL R1 gnt_n actual %b expected at most one low", gnt_n);
      end
    end

    // R1: reset in the middle withdraws the grant
    rst_n = 1'b0;
    #1;
    check(1, gnt_n, 3'b111);
    req_n = 3'b111; lock_n = 1'b1; sys_lock = 1'b0; rotate_sel = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1;
    step();
    rst_n = 1'b1;
    // R6: released request lines never get a grant
    repeat (3) begin
      step();
      check(6, gnt_n, 3'b111);
    end
    req_n = 3'b011;
    step();
    check(6, gnt_n, 3'b011); // R6 only m2 asks; m0,m1 high stay ungranted
    // R4: rotation after reset starts from m0
    rst_n = 1'b0;
    step();
    rst_n = 1'b1; rotate_sel = 1'b1; req_n = 3'b000;
    step();
    check(4, gnt_n, 3'b110);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule